// File: doc/BRIEF.md
# Echo Region Wipe Sequencer

This block clears the echo delay region of a 64 KiB audio sample RAM. It reads three register values: the page where the echo region begins, a delay register whose low nibble gives the region length in 2 KiB steps, and a flag register. A one-cycle start command then fills the region with 0xFF through a byte-wide synchronous write port.

The fill writes one byte per clock, in ascending address order, starting at the first byte of the region. If the region would run past the top of RAM, the fill stops at address 0xFFFF and does not wrap. If the flag register marks echo write-back as disabled, or the region is empty, no byte is written. In both cases the block still reports completion. The host waits on `done` or on the falling edge of `busy` before it uses the RAM again.

Top module: `echo_wipe`

## Requirements
- R1: The first byte written is at address `page_in * 256`.
- R2: The region length is `len_in[3:0] * 2048` bytes. Bits 7:4 of `len_in` have no effect.
- R3: The region ends at the lower of `base + length` and 0x10000. The last address written is never above 0xFFFF, and the address never wraps to 0.
- R4: Every write carries data 0xFF. Writes happen one per clock at consecutive ascending addresses, with no gaps.
- R5: When bit 5 of `flags_in` is 1, a start writes nothing and `done` pulses in the next cycle. The other flag bits have no effect on the fill.
- R6: When the length nibble is 0, a start gives no write enable, and `done` is high in the cycle right after the start cycle.
- R7: A start that arrives while `busy` is high is ignored. The running fill keeps its addresses and its length.
- R8: `busy` and `ram_we` are high in exactly the cycles in which a byte is written. `done` is high for exactly one cycle, which is the cycle after the last write.
- R9: While reset is applied, and right after it, `busy`, `done` and `ram_we` are low. A reset in the middle of a fill stops the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a wipe |
| page_in | input | 8 | Echo region start page |
| len_in | input | 8 | Delay register; the low nibble is the length in 2 KiB units |
| flags_in | input | 8 | Flag register; bit 5 set disables the wipe |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| busy | output | 1 | A fill is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the address steps by exactly one while the block is busy and never wraps;
- `done` is a single-cycle pulse that never overlaps `busy`;
- every fall of `busy` comes with `done`;
- a start that arrives mid-fill does not end the fill early.

Some behaviour only the bench scenarios can show:
- that the first and last addresses match the page, nibble and clipping arithmetic;
- that flag bit 5 suppresses every write while the other flag bits do not;
- that the upper bits of the length register are ignored;
- that a zero-length request completes one cycle after the start.

// File: rtl/echo_wipe.sv
module echo_wipe #(
  parameter int          AW          = 16,
  parameter int          PAGE_SHIFT  = 8,
  parameter int          LEN_W       = 4,
  parameter int          CHUNK_SHIFT = 11,
  parameter int          FLAG_BIT    = 5,
  parameter logic [7:0]  FILL        = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [AW-PAGE_SHIFT-1:0] page_in,
  input  logic [7:0]               len_in,
  input  logic [7:0]               flags_in,
  output logic [AW-1:0]            ram_addr,
  output logic [7:0]               ram_wdata,
  output logic                     ram_we,
  output logic                     busy,
  output logic                     done
);

  localparam int EW = AW + 2;
  localparam logic [EW-1:0] TOP = EW'(1) << AW;

  logic [EW-1:0] base_w, span_w, sum_w, end_w;
  logic          empty_w;
  logic [AW-1:0] cur_q, last_q;
  logic          unused_bits;

  assign base_w  = EW'(page_in) << PAGE_SHIFT;
  assign span_w  = EW'(len_in[LEN_W-1:0]) << CHUNK_SHIFT;
  assign sum_w   = base_w + span_w;
  assign end_w   = (sum_w > TOP) ? TOP : sum_w;
  assign empty_w = flags_in[FLAG_BIT] || (end_w == base_w);
  assign unused_bits = ^(flags_in & ~(8'd1 << FLAG_BIT)) ^ ^len_in ^ ^end_w;

  assign ram_addr  = cur_q;
  assign ram_wdata = FILL;
  assign ram_we    = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cur_q == last_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
      end else if (start) begin
        if (empty_w) begin
          done <= 1'b1;
        end else begin
          busy   <= 1'b1;
          cur_q  <= base_w[AW-1:0];
          last_q <= AW'(end_w - EW'(1));
        end
      end
    end
  end

  // R4 and R3: consecutive ascending addresses, no wrap
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(rst_n)) |->
      ({1'b0, ram_addr} == {1'b0, $past(ram_addr)} + 1'b1));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(rst_n)) |-> done);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && ram_addr != last_q) |=> busy);

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ram_addr == {AW{1'b1}}) |=> !busy);

endmodule

// File: tb/echo_wipe_tb.sv
module echo_wipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  page_in = '0, len_in = '0, flags_in = '0;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_we, busy, done;

  echo_wipe u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_in(page_in),
    .len_in(len_in), .flags_in(flags_in), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  page;
    logic [7:0]  len;
    logic [7:0]  flg;
    logic [31:0] cnt;
    logic [15:0] first;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h01, 8'h00, 32'd2048, 16'h0000},
    '{8'h10, 8'h02, 8'h00, 32'd4096, 16'h1000},
    '{8'hF8, 8'h0F, 8'h00, 32'd2048, 16'hF800},
    '{8'hFF, 8'h01, 8'h00, 32'd256,  16'hFF00},
    '{8'h40, 8'h00, 8'h00, 32'd0,    16'h0000},
    '{8'h20, 8'h03, 8'h20, 32'd0,    16'h0000},
    '{8'h20, 8'h03, 8'hDF, 32'd6144, 16'h2000},
    '{8'h80, 8'hF3, 8'h00, 32'd6144, 16'h8000},
    '{8'hE0, 8'h05, 8'h00, 32'd8192, 16'hE000}
  };

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int wcnt, dcnt, bad_step, bad_data, last_wcyc, done_cyc;
  logic [15:0] wfirst, wlast;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ram_we) begin
      if (wcnt == 0) wfirst = ram_addr;
      else if ({1'b0, ram_addr} != {1'b0, wlast} + 17'd1) bad_step++;
      if (ram_wdata != 8'hFF) bad_data++;
      wlast = ram_addr;
      last_wcyc = cyc;
      wcnt++;
    end
    if (ram_we != busy) bad_step++;
    if (done) begin
      dcnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    wcnt = 0; dcnt = 0; bad_step = 0; bad_data = 0;
    last_wcyc = -1; done_cyc = -1; wfirst = '0; wlast = '0;
  endtask

  task automatic kick(input vec_t v, output int scyc);
    @(negedge clk);
    page_in = v.page; len_in = v.len; flags_in = v.flg; start = 1'b1;
    scyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (dcnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int scyc;
    clr();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ram_we, "R9 reset state", {busy, done, ram_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !ram_we, "R9 after release", {busy, done, ram_we}, 0);

    for (int i = 0; i < NV; i++) begin
      clr();
      kick(VEC[i], scyc);
      wait_done();
      chk(wcnt == int'(VEC[i].cnt), "R2 R3 R5 byte count", wcnt, VEC[i].cnt);
      chk(dcnt == 1, "R8 done width", dcnt, 1);
      chk(bad_step == 0 && bad_data == 0, "R4 contiguous 0xFF writes", bad_step + bad_data, 0);
      if (VEC[i].cnt != 0) begin
        chk(wfirst == VEC[i].first, "R1 first address", wfirst, VEC[i].first);
        chk(wlast == VEC[i].first + 16'(VEC[i].cnt - 1), "R3 last address", wlast,
            VEC[i].first + 16'(VEC[i].cnt - 1));
        chk(done_cyc == last_wcyc + 1, "R8 done after last write", done_cyc, last_wcyc + 1);
      end else begin
        chk(done_cyc == scyc + 1, "R6 R5 done one cycle after start", done_cyc, scyc + 1);
      end
    end

    // R7: start during a fill is ignored
    clr();
    kick('{8'h10, 8'h01, 8'h00, 32'd2048, 16'h1000}, scyc);
    repeat (100) @(negedge clk);
    page_in = 8'h00; len_in = 8'h02; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(wcnt == 2048, "R7 count kept", wcnt, 2048);
    chk(wlast == 16'h17FF, "R7 last address kept", wlast, 16'h17FF);
    chk(bad_step == 0, "R7 no address jump", bad_step, 0);

    // R9: reset in the middle of a fill
    clr();
    kick('{8'h30, 8'h04, 8'h00, 32'd8192, 16'h3000}, scyc);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !ram_we && !done, "R9 mid-fill reset", {busy, ram_we, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !ram_we, "R9 stays idle", {busy, ram_we}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule